// File: doc/BRIEF.md
# UART Interrupt Identification and Line Status Controller

This block holds the interrupt and status logic of a UART with receive and transmit FIFOs. It takes the FIFO fill levels, the transmit shift-register empty flag, the per-character error strobes, a character-timeout strobe, a modem-change strobe, the FIFO enable, four interrupt enables and a trigger-level selector. From these it forms a prioritized interrupt identification byte, an interrupt request line and a line status byte. The serial shifters, baud generation, FIFO storage and register decode sit outside. Those parts supply plain level and strobe inputs, and they feed read strobes back to this block.

The four interrupt enables are independent of each other, so the receive side and the transmit side can each run either interrupt-driven or polled. The FIFO polled mode is the case where the FIFOs are on and every enable is off. In that mode the FIFOs keep buffering, the status byte keeps reporting, and the identification byte shows no pending interrupt. All three outputs are registered. Each output reflects the inputs and strobes that were sampled at the previous rising clock edge.

Top module: `uart_intr_ctl`

## Requirements
- R1: While `rst_n` is low, `iir_o` is 0x01, `irq_o` is 0 and `lsr_o` is 0x60.
- R2: The outputs change only at a rising clock edge. They show the result of the inputs sampled at that edge, so a change on an input becomes visible one edge later.
- R3: `iir_o[3:0]` holds the source code: 0x6 for a line error, 0x4 for receive data, 0xC for a character timeout, 0x2 for transmit empty, 0x0 for a modem change, and 0x1 when nothing is pending. `iir_o[5:4]` is 0, and `iir_o[7:6]` are both equal to `fifo_en`. `irq_o` is 1 exactly when bit 0 of the code is 0.
- R4: The priority order, from highest to lowest, is line error, then the receive tier (receive data and timeout), then transmit empty, then modem. Inside the receive tier, receive data shows code 0x4 ahead of timeout code 0xC.
- R5: The receive-data source is active when `ie_rx_data` is set and one of these holds. With `fifo_en` set, `rx_level` must be at or above the trigger level; `trig_sel` values 0, 1, 2 and 3 select 1, FIFO_DEPTH/4, FIFO_DEPTH/2 and FIFO_DEPTH-2. With `fifo_en` clear, `rx_level` only has to be non-zero. The source drops as soon as the level falls below that threshold.
- R6: A `char_timeout` strobe latches a timeout when `fifo_en` and `ie_rx_data` are set and `rx_level` is non-zero. The timeout clears on `rx_read`, when the receive FIFO empties, or when either enable is cleared.
- R7: A transmit-empty interrupt is raised when `tx_level` reaches 0, and only if `tx_write` has loaded at least one character since the previous empty indication. It clears on `tx_write`, or on `iir_read` while `iir_o` shows code 0x2.
- R8: When `fifo_en` rises while `ie_tx_empty` is set, the transmit-empty interrupt is raised at that same edge, even if no character has been written.
- R9: With an enable cleared, its source never appears in `iir_o`. With all four enables cleared, `irq_o` is 0. A `char_timeout` that arrives while `ie_rx_data` is clear is discarded and does not appear later.
- R10: The receive side can be polled while transmit interrupts still work. With only `ie_tx_empty` set, a full receive FIFO leaves the code at transmit empty or none, and `lsr_o[0]` still reports data.
- R11: `lsr_o[0]` is set while `rx_level` is non-zero. `lsr_o[5]` is set while `tx_level` is 0. `lsr_o[6]` is set while `tx_level` is 0 and `tsr_empty` is set. `lsr_o[7]` equals `rx_fifo_err` gated by `fifo_en`.
- R12: The error strobes for overrun, parity, framing and break set the sticky bits `lsr_o[1]`, `lsr_o[2]`, `lsr_o[3]` and `lsr_o[4]` in that order, whatever the enables are. The bits clear on `lsr_read`, and a strobe that arrives in the same cycle wins. Any set bit raises code 0x6 if `ie_line_err` is set.
- R13: A `modem_delta` strobe latches a modem change, which `msr_read` clears. It shows code 0x0 when `ie_modem` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| ie_line_err | input | 1 | Line-error interrupt enable |
| ie_rx_data | input | 1 | Receive data / timeout interrupt enable |
| ie_tx_empty | input | 1 | Transmit-empty interrupt enable |
| ie_modem | input | 1 | Modem-change interrupt enable |
| trig_sel | input | 2 | Receive trigger-level selector |
| rx_level | input | LVL_W | Characters in receive FIFO |
| tx_level | input | LVL_W | Characters in transmit FIFO |
| tsr_empty | input | 1 | Transmit shift register idle |
| rx_fifo_err | input | 1 | An errored character is still in the receive FIFO |
| err_overrun | input | 1 | Overrun strobe |
| err_parity | input | 1 | Parity error strobe |
| err_framing | input | 1 | Framing error strobe |
| err_break | input | 1 | Break strobe |
| char_timeout | input | 1 | Character timeout strobe |
| modem_delta | input | 1 | Modem input change strobe |
| tx_write | input | 1 | Character written to transmit FIFO |
| rx_read | input | 1 | Character read from receive FIFO |
| iir_read | input | 1 | Identification byte read strobe |
| lsr_read | input | 1 | Status byte read strobe |
| msr_read | input | 1 | Modem status read strobe |
| iir_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Interrupt request |
| lsr_o | output | 8 | Line status byte |

## Verification
The bench builds the block with FIFO_DEPTH = 16. This gives trigger levels of 1, 4, 8 and 14 and a 5-bit level that can reach 16. With those values, every threshold can be driven one character below and exactly at, and a full FIFO can be shown. The same build lets the transmit arming sequence, the FIFO-enable edge and each sticky error be driven cycle by cycle against a small depth.

// File: rtl/uart_ic_pkg.sv
package uart_ic_pkg;

    // Interrupt identification codes (low nibble of the identification byte)
    typedef enum logic [3:0] {
        ID_MODEM   = 4'h0,
        ID_NONE    = 4'h1,
        ID_TX      = 4'h2,
        ID_RXDATA  = 4'h4,
        ID_LINE    = 4'h6,
        ID_TIMEOUT = 4'hC
    } irq_id_e;

    // Sticky line errors; bit order matches status byte bits 4:1
    typedef struct packed {
        logic brk;
        logic framing;
        logic parity;
        logic overrun;
    } line_err_t;

    localparam int unsigned N_TRIG = 4;
    localparam int unsigned N_SRC  = 5;

    // Receive threshold for a selector value, scaled to the FIFO depth
    function automatic int unsigned trig_level(input int unsigned sel,
                                               input int unsigned depth);
        int unsigned lvl;
        case (sel)
            0:       lvl = 1;
            1:       lvl = depth / 4;
            2:       lvl = depth / 2;
            default: lvl = (depth > 2) ? depth - 2 : 1;
        endcase
        if (lvl < 1) lvl = 1;
        return lvl;
    endfunction

endpackage

// File: rtl/uart_ic_line.sv
module uart_ic_line
    import uart_ic_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_err_t err_in,
    input  logic      lsr_read,
    input  logic      modem_delta,
    input  logic      msr_read,
    input  logic      ie_line_err,
    input  logic      ie_modem,
    output line_err_t err_nxt,
    output logic      line_src,
    output logic      modem_src
);

    typedef struct packed {
        line_err_t err;
        logic      modem;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lsr_read) st_d.err = '0;
        st_d.err = line_err_t'(st_d.err | err_in);   // a new strobe wins over the read
        if (msr_read)    st_d.modem = 1'b0;
        if (modem_delta) st_d.modem = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_nxt   = st_d.err;
    assign line_src  = ie_line_err & (|st_d.err);
    assign modem_src = ie_modem & st_d.modem;

endmodule

// File: rtl/uart_ic_rx.sv
module uart_ic_rx
    import uart_ic_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             ie_rx_data,
    input  logic [1:0]       trig_sel,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             char_timeout,
    input  logic             rx_read,
    output logic             data_src,
    output logic             tmo_src
);

    logic [LVL_W-1:0] trig_tab [N_TRIG];

    for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
        assign trig_tab[g] = LVL_W'(trig_level(g, DEPTH));
    end

    typedef struct packed {
        logic tmo;
    } state_t;

    state_t st_d, st_q;
    logic   have_chars;
    logic   at_trig;
    logic   tmo_allowed;

    always_comb begin
        have_chars  = (rx_level != '0);
        at_trig     = fifo_en ? (rx_level >= trig_tab[trig_sel]) : have_chars;
        // timeouts exist only in FIFO interrupt mode with data waiting
        tmo_allowed = fifo_en & ie_rx_data & have_chars;
        st_d = st_q;
        if (!tmo_allowed || rx_read) st_d.tmo = 1'b0;
        else if (char_timeout)       st_d.tmo = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_src = ie_rx_data & at_trig;
    assign tmo_src  = st_d.tmo;

endmodule

// File: rtl/uart_ic_tx.sv
module uart_ic_tx #(
    parameter int unsigned LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             ie_tx_empty,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             tx_write,
    input  logic             iir_read,
    input  logic             iir_shows_tx,
    output logic             tx_src
);

    typedef struct packed {
        logic armed;    // a character went in since the last empty report
        logic pend;     // transmit-empty interrupt waiting
        logic fe_prev;  // FIFO enable seen at the previous edge
    } state_t;

    state_t st_d, st_q;
    logic   drained;
    logic   fe_rise;

    always_comb begin
        st_d         = st_q;
        st_d.fe_prev = fifo_en;
        fe_rise      = fifo_en & ~st_q.fe_prev;
        drained      = (tx_level == '0) & st_q.armed & ~tx_write;

        if (tx_write)              st_d.armed = 1'b1;
        else if (tx_level == '0)   st_d.armed = 1'b0;

        if (!ie_tx_empty)                 st_d.pend = 1'b0;
        else if (fe_rise)                 st_d.pend = 1'b1;
        else if (tx_write)                st_d.pend = 1'b0;
        else if (drained)                 st_d.pend = 1'b1;
        else if (iir_read & iir_shows_tx) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_src = st_d.pend;

endmodule

// File: rtl/uart_intr_ctl.sv
module uart_intr_ctl
    import uart_ic_pkg::*;
#(
    parameter  int unsigned FIFO_DEPTH = 16,
    localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             ie_line_err,
    input  logic             ie_rx_data,
    input  logic             ie_tx_empty,
    input  logic             ie_modem,
    input  logic [1:0]       trig_sel,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             tsr_empty,
    input  logic             rx_fifo_err,
    input  logic             err_overrun,
    input  logic             err_parity,
    input  logic             err_framing,
    input  logic             err_break,
    input  logic             char_timeout,
    input  logic             modem_delta,
    input  logic             tx_write,
    input  logic             rx_read,
    input  logic             iir_read,
    input  logic             lsr_read,
    input  logic             msr_read,
    output logic [7:0]       iir_o,
    output logic             irq_o,
    output logic [7:0]       lsr_o
);

    // Sources ranked from highest (index 0) to lowest priority
    localparam irq_id_e RANK_ID [N_SRC] = '{ID_LINE, ID_RXDATA, ID_TIMEOUT, ID_TX, ID_MODEM};

    typedef struct packed {
        logic [7:0] iir;
        logic       irq;
        logic [7:0] lsr;
    } out_t;

    localparam out_t OUT_RST = '{iir: 8'h01, irq: 1'b0, lsr: 8'h60};

    line_err_t        err_in, err_nxt;
    logic             line_src, modem_src, data_src, tmo_src, tx_src;
    logic [N_SRC-1:0] src;
    irq_id_e          id;
    out_t             out_d, out_q;

    assign err_in = '{brk: err_break, framing: err_framing, parity: err_parity, overrun: err_overrun};

    uart_ic_line line_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_in      (err_in),
        .lsr_read    (lsr_read),
        .modem_delta (modem_delta),
        .msr_read    (msr_read),
        .ie_line_err (ie_line_err),
        .ie_modem    (ie_modem),
        .err_nxt     (err_nxt),
        .line_src    (line_src),
        .modem_src   (modem_src)
    );

    uart_ic_rx #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) rx_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (fifo_en),
        .ie_rx_data   (ie_rx_data),
        .trig_sel     (trig_sel),
        .rx_level     (rx_level),
        .char_timeout (char_timeout),
        .rx_read      (rx_read),
        .data_src     (data_src),
        .tmo_src      (tmo_src)
    );

    uart_ic_tx #(.LVL_W(LVL_W)) tx_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (fifo_en),
        .ie_tx_empty  (ie_tx_empty),
        .tx_level     (tx_level),
        .tx_write     (tx_write),
        .iir_read     (iir_read),
        .iir_shows_tx (out_q.iir[3:0] == ID_TX),
        .tx_src       (tx_src)
    );

    assign src = {modem_src, tx_src, tmo_src, data_src, line_src};

    always_comb begin
        id = ID_NONE;
        for (int r = N_SRC - 1; r >= 0; r--) begin
            if (src[r]) id = RANK_ID[r];
        end

        out_d.iir    = {fifo_en, fifo_en, 2'b00, id};
        out_d.irq    = (id != ID_NONE);
        out_d.lsr[0] = (rx_level != '0);
        out_d.lsr[4:1] = err_nxt;
        out_d.lsr[5] = (tx_level == '0);
        out_d.lsr[6] = (tx_level == '0) & tsr_empty;
        out_d.lsr[7] = fifo_en & rx_fifo_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= OUT_RST;
        else        out_q <= out_d;
    end

    assign iir_o = out_q.iir;
    assign irq_o = out_q.irq;
    assign lsr_o = out_q.lsr;

endmodule

// File: rtl/uart_intr_ctl_chk.sv
module uart_intr_ctl_chk #(
    parameter int unsigned LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             ie_line_err,
    input logic             ie_rx_data,
    input logic             ie_tx_empty,
    input logic             ie_modem,
    input logic             err_overrun,
    input logic             err_parity,
    input logic             err_framing,
    input logic             err_break,
    input logic             lsr_read,
    input logic [LVL_W-1:0] rx_level,
    input logic [7:0]       iir_o,
    input logic             irq_o,
    input logic [7:0]       lsr_o
);

    assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_o[3:0] inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'hC}) && iir_o[5:4] == 2'b00);

    assert_line_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_line_err && (err_overrun || err_parity || err_framing || err_break))
        |=> iir_o[3:0] == 4'h6);

    assert_fifo_on_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fifo_en) && ie_tx_empty) |=> irq_o);

    assert_polled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_line_err && !ie_rx_data && !ie_tx_empty && !ie_modem) |=> !irq_o);

    assert_no_tmo_polled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_rx_data |=> iir_o[3:0] != 4'hC);

    assert_data_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level != '0) |=> lsr_o[0]);

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_o[1] && !lsr_read) |=> lsr_o[1]);

endmodule

bind uart_intr_ctl uart_intr_ctl_chk #(.LVL_W(LVL_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_en     (fifo_en),
    .ie_line_err (ie_line_err),
    .ie_rx_data  (ie_rx_data),
    .ie_tx_empty (ie_tx_empty),
    .ie_modem    (ie_modem),
    .err_overrun (err_overrun),
    .err_parity  (err_parity),
    .err_framing (err_framing),
    .err_break   (err_break),
    .lsr_read    (lsr_read),
    .rx_level    (rx_level),
    .iir_o       (iir_o),
    .irq_o       (irq_o),
    .lsr_o       (lsr_o)
);

// File: tb/uart_intr_ctl_tb_top.sv
`timescale 1ns/1ps
module uart_intr_ctl_tb_top;

    localparam int unsigned DEPTH = 16;
    localparam int unsigned LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 0, ie_line_err = 0, ie_rx_data = 0, ie_tx_empty = 0, ie_modem = 0;
    logic [1:0]    trig_sel = '0;
    logic [LW-1:0] rx_level = '0, tx_level = '0;
    logic          tsr_empty = 1, rx_fifo_err = 0;
    logic          err_overrun = 0, err_parity = 0, err_framing = 0, err_break = 0;
    logic          char_timeout = 0, modem_delta = 0, tx_write = 0, rx_read = 0;
    logic          iir_read = 0, lsr_read = 0, msr_read = 0;
    logic [7:0]    iir_o, lsr_o;
    logic          irq_o;

    always #10 clk = ~clk;

    uart_intr_ctl #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .ie_line_err(ie_line_err), .ie_rx_data(ie_rx_data),
        .ie_tx_empty(ie_tx_empty), .ie_modem(ie_modem),
        .trig_sel(trig_sel), .rx_level(rx_level), .tx_level(tx_level),
        .tsr_empty(tsr_empty), .rx_fifo_err(rx_fifo_err),
        .err_overrun(err_overrun), .err_parity(err_parity),
        .err_framing(err_framing), .err_break(err_break),
        .char_timeout(char_timeout), .modem_delta(modem_delta),
        .tx_write(tx_write), .rx_read(rx_read), .iir_read(iir_read),
        .lsr_read(lsr_read), .msr_read(msr_read),
        .iir_o(iir_o), .irq_o(irq_o), .lsr_o(lsr_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // ie field order: {line, rx, tx, modem}
    typedef struct packed {
        logic          fe;
        logic [3:0]    ie;
        logic [1:0]    trig;
        logic [4:0]    rxl;
        logic [4:0]    txl;
        logic          tsr;
        logic [7:0]    iir;
        logic          irq;
        logic [7:0]    lsr;
    } vec_t;

    localparam int N_VEC = 13;
    localparam vec_t VEC [N_VEC] = '{
        '{1'b1, 4'b0100, 2'd0, 5'd0,  5'd0, 1'b1, 8'hC1, 1'b0, 8'h60},
        '{1'b1, 4'b0100, 2'd0, 5'd1,  5'd0, 1'b1, 8'hC4, 1'b1, 8'h61},
        '{1'b1, 4'b0100, 2'd1, 5'd3,  5'd2, 1'b0, 8'hC1, 1'b0, 8'h01},
        '{1'b1, 4'b0100, 2'd1, 5'd4,  5'd2, 1'b1, 8'hC4, 1'b1, 8'h01},
        '{1'b1, 4'b0100, 2'd2, 5'd7,  5'd0, 1'b0, 8'hC1, 1'b0, 8'h21},
        '{1'b1, 4'b0100, 2'd2, 5'd8,  5'd0, 1'b0, 8'hC4, 1'b1, 8'h21},
        '{1'b1, 4'b0100, 2'd3, 5'd13, 5'd0, 1'b1, 8'hC1, 1'b0, 8'h61},
        '{1'b1, 4'b0100, 2'd3, 5'd14, 5'd0, 1'b1, 8'hC4, 1'b1, 8'h61},
        '{1'b1, 4'b0100, 2'd3, 5'd16, 5'd0, 1'b1, 8'hC4, 1'b1, 8'h61},
        '{1'b1, 4'b0000, 2'd0, 5'd5,  5'd0, 1'b1, 8'hC1, 1'b0, 8'h61},
        '{1'b0, 4'b0100, 2'd3, 5'd1,  5'd0, 1'b1, 8'h04, 1'b1, 8'h61},
        '{1'b0, 4'b0100, 2'd3, 5'd0,  5'd0, 1'b1, 8'h01, 1'b0, 8'h60},
        '{1'b1, 4'b0100, 2'd3, 5'd5,  5'd3, 1'b0, 8'hC1, 1'b0, 8'h01}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic chk1(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic set_ie(input logic [3:0] v);
        {ie_line_err, ie_rx_data, ie_tx_empty, ie_modem} = v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk8("R1", "iir in reset", iir_o, 8'h01);
        chk1("R1", "irq in reset", irq_o, 1'b0);
        chk8("R1", "lsr in reset", lsr_o, 8'h60);
        rst_n = 1'b1;
        tick();
        chk8("R1", "iir after release", iir_o, 8'h01);

        // table: R3 codes, R5 thresholds, R9 polled, R11 status bits
        for (int i = 0; i < N_VEC; i++) begin
            fifo_en = VEC[i].fe; set_ie(VEC[i].ie); trig_sel = VEC[i].trig;
            rx_level = VEC[i].rxl; tx_level = VEC[i].txl; tsr_empty = VEC[i].tsr;
            tick();
            chk8("R3/R5", $sformatf("table %0d iir", i), iir_o, VEC[i].iir);
            chk1("R3/R9", $sformatf("table %0d irq", i), irq_o, VEC[i].irq);
            chk8("R11", $sformatf("table %0d lsr", i), lsr_o, VEC[i].lsr);
        end

        // quiet state
        set_ie(4'b0000); fifo_en = 1; trig_sel = 0; rx_level = 0; tx_level = 0; tsr_empty = 1;
        tick();

        // R2 one-edge latency
        ie_rx_data = 1; rx_level = 1;
        #1 chk1("R2", "irq before edge", irq_o, 1'b0);
        tick();
        chk1("R2", "irq after edge", irq_o, 1'b1);
        ie_rx_data = 0; rx_level = 0;
        tick();

        // R7 transmit-empty arming
        ie_tx_empty = 1;
        tick();
        chk8("R7", "no write yet", iir_o, 8'hC1);
        tx_write = 1; tick(); tx_write = 0; tx_level = 1;
        chk8("R7", "write cycle", iir_o, 8'hC1);
        tick();
        chk8("R7", "fifo busy", iir_o, 8'hC1);
        tx_level = 0; tick();
        chk8("R7", "drained", iir_o, 8'hC2);
        chk1("R7", "drained irq", irq_o, 1'b1);
        iir_read = 1; tick(); iir_read = 0;
        chk8("R7", "cleared by id read", iir_o, 8'hC1);
        tick();
        chk8("R7", "no re-raise without write", iir_o, 8'hC1);
        tx_write = 1; tick(); tx_write = 0; tx_level = 1;
        tick(); tx_level = 0; tick();
        chk8("R7", "second drain", iir_o, 8'hC2);
        tx_write = 1; tick(); tx_write = 0; tx_level = 1;
        chk8("R7", "cleared by write", iir_o, 8'hC1);
        tx_level = 0; tick();
        chk8("R7", "third drain", iir_o, 8'hC2);
        iir_read = 1; tick(); iir_read = 0;
        ie_tx_empty = 0; tick();

        // R8 FIFO enable edge, R4 tx over modem, R13 modem
        set_ie(4'b0011); fifo_en = 0; tick();
        chk8("R8", "fifo off idle", iir_o, 8'h01);
        modem_delta = 1; tick(); modem_delta = 0;
        chk8("R13", "modem code", iir_o, 8'h00);
        chk1("R13", "modem irq", irq_o, 1'b1);
        fifo_en = 1; tick();
        chk8("R8", "enable raises tx at once", iir_o, 8'hC2);
        iir_read = 1; tick(); iir_read = 0;
        chk8("R4", "modem below tx", iir_o, 8'hC0);
        msr_read = 1; tick(); msr_read = 0;
        chk8("R13", "modem cleared", iir_o, 8'hC1);

        // R4 / R12 line errors
        set_ie(4'b1101); trig_sel = 0; rx_level = 1;
        modem_delta = 1; err_parity = 1; tick(); modem_delta = 0; err_parity = 0;
        chk8("R4", "line error on top", iir_o, 8'hC6);
        chk8("R12", "parity bit", lsr_o, 8'h65);
        tick();
        chk8("R12", "error sticky", lsr_o, 8'h65);
        lsr_read = 1; tick(); lsr_read = 0;
        chk8("R4", "rx tier after clear", iir_o, 8'hC4);
        chk8("R12", "status read clears", lsr_o, 8'h61);
        rx_level = 0; tick();
        chk8("R4", "modem last", iir_o, 8'hC0);
        msr_read = 1; tick(); msr_read = 0;
        set_ie(4'b0100);
        err_overrun = 1; tick(); err_overrun = 0;
        chk8("R12", "overrun without line enable iir", iir_o, 8'hC1);
        chk8("R12", "overrun bit", lsr_o, 8'h62);
        err_break = 1; lsr_read = 1; tick(); err_break = 0; lsr_read = 0;
        chk8("R12", "strobe beats read", lsr_o, 8'h70);
        lsr_read = 1; tick(); lsr_read = 0;

        // R6 timeout
        trig_sel = 3; rx_level = 3; tick();
        chk8("R6", "below trigger", iir_o, 8'hC1);
        char_timeout = 1; tick(); char_timeout = 0;
        chk8("R6", "timeout code", iir_o, 8'hCC);
        rx_level = 14; tick();
        chk8("R4", "data code over timeout", iir_o, 8'hC4);
        rx_level = 3; tick();
        chk8("R6", "timeout held", iir_o, 8'hCC);
        rx_read = 1; tick(); rx_read = 0;
        chk8("R6", "read clears timeout", iir_o, 8'hC1);
        rx_level = 0; char_timeout = 1; tick(); char_timeout = 0;
        chk8("R6", "empty fifo no timeout", iir_o, 8'hC1);

        // R9 polled receive drops timeout
        rx_level = 3; ie_rx_data = 0; char_timeout = 1; tick(); char_timeout = 0;
        chk8("R9", "polled timeout", iir_o, 8'hC1);
        ie_rx_data = 1; tick();
        chk8("R9", "timeout discarded", iir_o, 8'hC1);

        // R10 rx polled, tx interrupt
        set_ie(4'b0010); rx_level = 14; fifo_en = 0; tick();
        chk8("R10", "rx polled full", iir_o, 8'h01);
        fifo_en = 1; tick();
        chk8("R10", "tx interrupt", iir_o, 8'hC2);
        chk8("R10", "data ready seen", lsr_o, 8'h61);
        iir_read = 1; tick(); iir_read = 0;
        chk8("R10", "rx still silent", iir_o, 8'hC1);

        // R11 status bits
        set_ie(4'b0000); rx_fifo_err = 1; tick();
        chk8("R11", "fifo error bit", lsr_o, 8'hE1);
        fifo_en = 0; tick();
        chk8("R11", "fifo error gated", lsr_o, 8'h61);
        tsr_empty = 0; tick();
        chk8("R11", "shifter busy", lsr_o, 8'h21);
        tx_level = 2; tsr_empty = 1; tick();
        chk8("R11", "tx fifo busy", lsr_o, 8'h01);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule